// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block turns a single asynchronous serial line into bytes. A free-running enable pulse, `tick`, arrives at sixteen times the bit rate and is the block's only sense of time. The line rests high. A high-to-low transition announces a start bit, which is checked again half a bit later. If the line is still low, the receiver reads every later bit at its centre.

The frame layout is chosen at run time through three small configuration fields:

- the data width, 5 to 8 bits;
- the parity mode, none, even or odd;
- the stop length, one, one and a half, or two bit times.

The block captures the fields when it accepts a start edge, so a change made during a frame takes effect only for the next one.

When the last stop sample has been taken, the block updates the received byte and both error flags together. A one-cycle strobe marks the frame as accepted when every format check has passed.

Top module: `async_frame_rx`

## Requirements
- R1: After reset `rx_valid`, `parity_err` and `frame_err` are 0 and `rx_data` is 0.
- R2: Data bits arrive least significant first, and their count is 5 + `cfg_len` (code 0 gives 5, code 3 gives 8). Bits of `rx_data` above the configured width read 0.
- R3: `cfg_parity` selects the parity mode: 0 or 3 means no parity bit, 1 means even, 2 means odd. With even or odd parity, one parity bit follows the data. `parity_err` is 1 when the count of ones in data plus parity does not match the selected mode.
- R4: `cfg_stop` selects the stop period: 0 gives 16 ticks, 1 gives 24 ticks, 2 or 3 give 32 ticks. The period is counted from the centre of the last data or parity bit. The line is sampled after every 16th tick of the period and at its final tick. Any low sample sets `frame_err`.
- R5: When the line reads high at the 8th tick after a start edge, the edge is dropped as a glitch. No output changes and the receiver waits for the next falling edge.
- R6: `rx_valid` is high for exactly one clock cycle per frame. It pulses only when both `parity_err` and `frame_err` are 0 for that frame.
- R7: Every completed frame, whether accepted or not, updates `rx_data`, `parity_err` and `frame_err` in the cycle of its last stop sample. They keep those values until the next completed frame.
- R8: All bit timing counts `tick` pulses and not clock cycles, so a different spacing of `tick` gives the same results.
- R9: A start edge that follows the stop period directly, with no idle gap, begins a new frame.
- R10: The configuration is captured at the start edge, and changes to it during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample enable at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data width code, width = 5 + code |
| cfg_parity | input | 2 | Parity mode: 0/3 none, 1 even, 2 odd |
| cfg_stop | input | 2 | Stop period: 0 one bit, 1 one and a half, 2/3 two bits |
| rx_data | output | 8 | Last received data, right aligned |
| rx_valid | output | 1 | One-cycle strobe for an accepted frame |
| parity_err | output | 1 | Parity mismatch on the last completed frame |
| frame_err | output | 1 | Low stop sample on the last completed frame |

## Verification
The assertions assume that `tick` is a single-cycle pulse at least two clock cycles apart from the next one. They also assume that each frame lasts many ticks, so that two frame ends can never fall on adjacent cycles. The bench keeps every bit a whole number of ticks long, with the tick spacing set to two or three clocks. It changes that spacing only while the line is idle, and it scrambles the configuration pins only in the directed case that checks R10.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int RX_OVS   = 16;            // ticks per bit
    localparam int RX_HALF  = RX_OVS / 2;    // ticks to start-bit centre
    localparam int RX_DW    = 8;             // widest data field
    localparam int RX_MINW  = 5;             // narrowest data field
    localparam int RX_CW    = $clog2(2 * RX_OVS) + 1;
    localparam int RX_IW    = $clog2(RX_DW) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] par;
        logic [1:0] stop;
    } rx_cfg_t;

    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             pbit;
        logic [1:0]       par;
        logic             stop_ok;
    } rx_frame_t;

    function automatic logic [RX_IW-1:0] data_width(input logic [1:0] code);
        return RX_IW'(RX_MINW) + RX_IW'(code);
    endfunction

    function automatic logic [RX_CW-1:0] stop_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return RX_CW'(RX_OVS);
            2'd1:    return RX_CW'(RX_OVS + RX_HALF);
            default: return RX_CW'(2 * RX_OVS);
        endcase
    endfunction

    function automatic logic parity_on(input logic [1:0] code);
        return (code == 2'd1) || (code == 2'd2);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b1;
                    else     q[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q[i] <= 1'b1;
                    else     q[i] <= q[i-1];
                end
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line,
    input  rx_cfg_t   cfg,
    output logic      done,
    output rx_frame_t frame
);
    rx_state_e        state;
    rx_cfg_t          cfg_q;
    logic [RX_CW-1:0] tcnt;
    logic [RX_CW-1:0] tnext;
    logic [RX_IW-1:0] bidx;
    logic [RX_DW-1:0] sh;
    logic             prev;
    logic             pbit;
    logic             stop_ok;
    logic [RX_IW-1:0] nbits;
    logic [RX_CW-1:0] slen;
    logic             at_bit;

    assign tnext  = tcnt + 1'b1;
    assign nbits  = data_width(cfg_q.len);
    assign slen   = stop_ticks(cfg_q.stop);
    assign at_bit = (tnext % RX_CW'(RX_OVS)) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg_q   <= '0;
            tcnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            prev    <= 1'b1;
            pbit    <= 1'b0;
            stop_ok <= 1'b1;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev <= line;
                case (state)
                    ST_IDLE: begin
                        if (prev && !line) begin
                            state <= ST_START;
                            tcnt  <= '0;
                            cfg_q <= cfg;
                        end
                    end
                    ST_START: begin
                        if (tnext == RX_CW'(RX_HALF)) begin
                            tcnt  <= '0;
                            bidx  <= '0;
                            state <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tnext;
                        end
                    end
                    ST_DATA: begin
                        if (tnext == RX_CW'(RX_OVS)) begin
                            tcnt <= '0;
                            sh   <= {line, sh[RX_DW-1:1]};
                            if (bidx == nbits - 1'b1) begin
                                stop_ok <= 1'b1;
                                state   <= parity_on(cfg_q.par) ? ST_PAR : ST_STOP;
                            end else begin
                                bidx <= bidx + 1'b1;
                            end
                        end else begin
                            tcnt <= tnext;
                        end
                    end
                    ST_PAR: begin
                        if (tnext == RX_CW'(RX_OVS)) begin
                            tcnt  <= '0;
                            pbit  <= line;
                            state <= ST_STOP;
                        end else begin
                            tcnt <= tnext;
                        end
                    end
                    ST_STOP: begin
                        tcnt <= tnext;
                        if (at_bit || tnext == slen) stop_ok <= stop_ok & line;
                        if (tnext == slen) begin
                            state         <= ST_IDLE;
                            done          <= 1'b1;
                            frame.data    <= sh >> (RX_IW'(RX_DW) - nbits);
                            frame.pbit    <= pbit;
                            frame.par     <= cfg_q.par;
                            frame.stop_ok <= stop_ok & line;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R5: a high line at the start-bit centre sends the receiver back to idle
    p_glitch_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && tick && tnext == RX_CW'(RX_HALF) && line)
        |=> state == ST_IDLE);

    // R4: the stop counter never runs past the configured stop period
    p_stop_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> tcnt < slen);

    // R8: the receiver state only moves on a tick
    p_state_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state));

    // R7: a frame ends only when leaving the stop phase
    p_done_from_stop_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state) == ST_STOP && state == ST_IDLE);
endmodule

// File: rtl/rx_result_reg.sv
module rx_result_reg
    import serial_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  rx_frame_t        frame,
    output logic [RX_DW-1:0] rx_data,
    output logic             rx_valid,
    output logic             parity_err,
    output logic             frame_err
);
    logic perr;
    logic ferr;

    always_comb begin
        case (frame.par)
            2'd1:    perr = (^frame.data) ^ frame.pbit;
            2'd2:    perr = ~((^frame.data) ^ frame.pbit);
            default: perr = 1'b0;
        endcase
        ferr = ~frame.stop_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (done) begin
                rx_data    <= frame.data;
                parity_err <= perr;
                frame_err  <= ferr;
                rx_valid   <= ~(perr | ferr);
            end
        end
    end

    // R7: results only change on a completed frame
    p_hold_results_r7: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rx_data) && $stable(parity_err) && $stable(frame_err));
endmodule

// File: rtl/async_frame_rx.sv
module async_frame_rx
    import serial_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rx_in,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_parity,
    input  logic [1:0]       cfg_stop,
    output logic [RX_DW-1:0] rx_data,
    output logic             rx_valid,
    output logic             parity_err,
    output logic             frame_err
);
    logic      line_s;
    logic      done;
    rx_frame_t frame;
    rx_cfg_t   cfg;

    assign cfg = '{len: cfg_len, par: cfg_parity, stop: cfg_stop};

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_in),
        .dout (line_s)
    );

    rx_frame_fsm i_fsm (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .line  (line_s),
        .cfg   (cfg),
        .done  (done),
        .frame (frame)
    );

    rx_result_reg i_res (
        .clk        (clk),
        .rst        (rst),
        .done       (done),
        .frame      (frame),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .parity_err (parity_err),
        .frame_err  (frame_err)
    );

    // R6: the accept strobe lasts one cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6: an accepted frame carries no error flag
    p_valid_clean_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !parity_err && !frame_err);

    // R8: a strobe only follows a tick
    p_valid_after_tick_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid) |-> $past(tick, 2));
endmodule

// File: tb/test_async_frame_rx.sv
`timescale 1ns/1ps
module test_async_frame_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_parity = 2'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       parity_err;
    logic       frame_err;
    logic       tick;
    int         tick_div = 2;
    int         tcnt = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         vcount = 0;
    int         wide_pulse = 0;
    logic       prev_valid = 1'b0;
    logic [7:0] caps [0:7];

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (tcnt >= tick_div - 1) tcnt <= 0;
        else                      tcnt <= tcnt + 1;
    end
    assign tick = (tcnt == 0);

    async_frame_rx i_async_frame_rx (
        .clk(clk), .rst(rst), .tick(tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .parity_err(parity_err), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            caps[vcount % 8] <= rx_data;
            vcount <= vcount + 1;
            if (prev_valid) wide_pulse <= wide_pulse + 1;
        end
        prev_valid <= rx_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int ticks);
        rx_in = v;
        repeat (ticks * tick_div) @(negedge clk);
    endtask

    function automatic int stop_len(input logic [1:0] s);
        return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
    endfunction

    function automatic logic [7:0] mask_data(input logic [7:0] d, input logic [1:0] l);
        return d & 8'((9'd1 << (5 + l)) - 1);
    endfunction

    // kind: 0 clean, 1 parity flipped, 2 stop low at its end; scramble alters cfg mid-frame
    task automatic send(input logic [1:0] l, input logic [1:0] p, input logic [1:0] s,
                        input logic [7:0] d, input int kind, input bit scramble);
        logic [7:0] md;
        logic       pb;
        md = mask_data(d, l);
        cfg_len = l; cfg_parity = p; cfg_stop = s;
        @(negedge clk);
        hold(1'b0, 16);
        if (scramble) begin
            cfg_len = ~l; cfg_parity = p ^ 2'd3; cfg_stop = ~s;
        end
        for (int i = 0; i < 5 + l; i++) hold(md[i], 16);
        if (p == 2'd1 || p == 2'd2) begin
            pb = (p == 2'd1) ? ^md : ~^md;
            if (kind == 1) pb = ~pb;
            hold(pb, 16);
        end
        hold(1'b1, stop_len(s) - 8);
        hold(kind == 2 ? 1'b0 : 1'b1, 8);
        cfg_len = l; cfg_parity = p; cfg_stop = s;
    endtask

    task automatic frame_chk(input logic [1:0] l, input logic [1:0] p, input logic [1:0] s,
                             input logic [7:0] d, input int kind, input bit scramble,
                             input string req);
        int v0;
        logic [7:0] md;
        v0 = vcount;
        md = mask_data(d, l);
        send(l, p, s, d, kind, scramble);
        hold(1'b1, 20);
        chk(rx_data == md, req, rx_data, md);
        chk(parity_err == (kind == 1), req, parity_err, kind == 1);
        chk(frame_err == (kind == 2), req, frame_err, kind == 2);
        chk((vcount - v0) == (kind == 0 ? 1 : 0), req, vcount - v0, kind == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int v0;
        logic [7:0] d0;
        logic       p0;
        logic       f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_valid == 0 && parity_err == 0 && frame_err == 0, "R1", {rx_valid, parity_err, frame_err}, 0);
        chk(rx_data == 0, "R1", rx_data, 0);
        hold(1'b1, 20);

        // R2 widths and LSB-first order
        frame_chk(2'd3, 2'd0, 2'd0, 8'hA5, 0, 0, "R2");
        frame_chk(2'd0, 2'd0, 2'd0, 8'hF3, 0, 0, "R2");
        frame_chk(2'd1, 2'd3, 2'd0, 8'h6D, 0, 0, "R2");
        // R3 parity modes and errors
        frame_chk(2'd3, 2'd1, 2'd0, 8'h81, 0, 0, "R3");
        frame_chk(2'd2, 2'd2, 2'd0, 8'h55, 0, 0, "R3");
        frame_chk(2'd3, 2'd1, 2'd0, 8'h07, 1, 0, "R3");
        frame_chk(2'd0, 2'd2, 2'd2, 8'h1E, 1, 0, "R3");
        // R4 stop lengths and bad stop samples
        frame_chk(2'd3, 2'd0, 2'd1, 8'h3C, 0, 0, "R4");
        frame_chk(2'd3, 2'd0, 2'd2, 8'hC3, 0, 0, "R4");
        frame_chk(2'd3, 2'd0, 2'd0, 8'h11, 2, 0, "R4");
        frame_chk(2'd3, 2'd1, 2'd1, 8'h22, 2, 0, "R4");
        frame_chk(2'd1, 2'd0, 2'd2, 8'h33, 2, 0, "R4");

        // R5 start glitch leaves outputs untouched
        d0 = rx_data; p0 = parity_err; f0 = frame_err; v0 = vcount;
        hold(1'b0, 4);
        hold(1'b1, 30);
        chk(rx_data == d0 && parity_err == p0 && frame_err == f0, "R5",
            {rx_data, parity_err, frame_err}, {d0, p0, f0});
        chk(vcount == v0, "R5", vcount, v0);
        frame_chk(2'd3, 2'd0, 2'd0, 8'h5A, 0, 0, "R5");

        // R9 back-to-back frames with no idle gap
        v0 = vcount;
        send(2'd3, 2'd1, 2'd0, 8'h12, 0, 0);
        send(2'd3, 2'd1, 2'd0, 8'h34, 0, 0);
        hold(1'b1, 20);
        chk(vcount - v0 == 2, "R9", vcount - v0, 2);
        chk(caps[v0 % 8] == 8'h12, "R9", caps[v0 % 8], 8'h12);
        chk(caps[(v0 + 1) % 8] == 8'h34, "R9", caps[(v0 + 1) % 8], 8'h34);

        // R10 configuration captured at the start edge
        frame_chk(2'd2, 2'd1, 2'd1, 8'h4B, 0, 1, "R10");

        // R8 slower tick spacing
        tick_div = 3;
        hold(1'b1, 4);
        frame_chk(2'd3, 2'd2, 2'd1, 8'h9E, 0, 0, "R8");
        frame_chk(2'd0, 2'd1, 2'd2, 8'h0B, 1, 0, "R8");

        // R7 random mix of formats and errors
        void'($urandom(32'd1234));
        for (int n = 0; n < 36; n++) begin
            logic [1:0] l;
            logic [1:0] p;
            logic [1:0] s;
            int         k;
            tick_div = (n % 2 == 0) ? 2 : 3;
            hold(1'b1, 4);
            l = 2'($urandom_range(0, 3));
            p = 2'($urandom_range(0, 3));
            s = 2'($urandom_range(0, 3));
            k = $urandom_range(0, 2);
            if (k == 1 && !(p == 2'd1 || p == 2'd2)) k = 0;
            frame_chk(l, p, s, 8'($urandom), k, 0, "R7");
        end

        // R6 strobe width over the whole run
        chk(wide_pulse == 0, "R6", wide_pulse, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule